// File: doc/BRIEF.md
# Low-Power Mode Register and Power Sequencer

This block carries the low-power control logic of a pseudo-static RAM. A dedicated active-low sleep pin (`zz_ni`) drives it. The block holds a 5-bit mode register. It also runs the power state machine: power-up wait, standby, active, register programming, partial-refresh sleep, deep power-down and wake-up recovery. It keeps one data-valid flag for each quarter of the array and a ready flag that is high only when ordinary accesses may proceed. It also reports whether the address on the bus falls inside the region that the current mode retains or leaves usable.

The mode register is loaded by an ordinary write cycle made while `zz_ni` is low. Its value comes from address bits 4:0, and the new value takes effect on the rising edge of `zz_ni`. When `zz_ni` falls and no register write starts within an entry window, the block goes to sleep. It enters deep power-down if mode bit 4 is 0 and partial refresh if bit 4 is 1. All windows are given in nanoseconds and converted to clock cycles from a clock-period parameter.

Top module: `lp_mode_ctrl`

## Requirements
- R1: After reset `state_o` is 0 (power-up), `ready_o` is 0, `valid_o` is 0000 and `mode_o` is 00000. The block moves to standby (code 1) only after `cs_ni` has been high for the power-up time. Any cycle with `cs_ni` low restarts that wait.
- R2: From standby, `cs_ni` low with `lb_ni` or `ub_ni` low moves the block to active (code 2). Active returns to standby when `cs_ni` goes high or when both byte enables go high.
- R3: When `zz_ni` goes low, the block enters the sleep-pending state (code 3). A write cycle there (`cs_ni`, `we_ni` and a byte enable all low) moves it to programming (code 4) and stages `addr_i[4:0]`; the other address bits are ignored. `mode_o` keeps its old value until `zz_ni` rises, then takes the staged value.
- R4: Mode bits: [1:0] area (00 full, 01 treated as full, 10 half, 11 quarter), [2] top (1) or bottom (0), [3] reduced-size (1) or partial-refresh (0), [4] array kept on in sleep. Quarter index = `addr_i[17:16]`. The region is all quarters for full, quarters 0–1 (bottom) or 2–3 (top) for half, and quarter 0 (bottom) or 3 (top) for quarter. `region_hit_o` is 1 exactly when the addressed quarter lies in the region.
- R5: If `zz_ni` stays low for the entry window with no register write, the block sleeps: code 5 (partial refresh) when bit 4 is 1, code 6 (deep power-down) when bit 4 is 0.
- R6: If `zz_ni` rises before the entry window ends with no write, the block returns to standby, `mode_o` is unchanged and no sleep follows.
- R7: On entry to partial refresh, valid flags outside the region clear and flags inside it are kept. `ready_o` is 0 in every state except standby and active.
- R8: Deep power-down clears all valid flags. Its exit passes through recovery (code 7) with `ready_o` low for the recovery time, then returns to standby.
- R9: Exit from either sleep state waits until `zz_ni` has been low for the minimum sleep time, even if `zz_ni` rises earlier.
- R10: A write in active state with `zz_ni` high sets the valid flag of the addressed quarter. In reduced-size mode, a write outside the region sets no flag.
- R11: The mode, including reduced-size, stays in force across sleep and wake until it is reprogrammed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| we_ni | input | 1 | Write enable, active low |
| lb_ni | input | 1 | Lower byte enable, active low |
| ub_ni | input | 1 | Upper byte enable, active low |
| zz_ni | input | 1 | Sleep pin, active low |
| addr_i | input | 18 | Word address; bits 4:0 carry the mode value during programming |
| state_o | output | 3 | Power state code |
| mode_o | output | 5 | Active mode register |
| valid_o | output | 4 | Data-valid flag per array quarter |
| ready_o | output | 1 | Ordinary accesses allowed |
| region_hit_o | output | 1 | Address lies in the retained/usable region |

## Verification
The assertions watch, on every cycle, the properties that hold in every state:
- `mode_o` changes only when programming is closed by a rising `zz_ni`.
- Either sleep state is entered only from sleep-pending, and the one entered agrees with mode bit 4.
- Deep power-down never shows a valid flag, and partial refresh never shows a flag outside the region.
- Recovery leads only to standby, and ready is never high outside standby and active.

Only the bench's scenarios can show the timed behaviour and the decoding:
- the power-up restart;
- the entry window;
- the deferred exit;
- the recovery length;
- the region decoding for all 32 mode values;
- the masking of writes in reduced-size mode.

// File: rtl/lp_pkg.sv
package lp_pkg;
  typedef enum logic [2:0] {
    ST_PWRUP  = 3'd0,
    ST_STBY   = 3'd1,
    ST_ACT    = 3'd2,
    ST_ZZWAIT = 3'd3,
    ST_PROG   = 3'd4,
    ST_PAR    = 3'd5,
    ST_DPD    = 3'd6,
    ST_RECOV  = 3'd7
  } lp_state_e;

  typedef struct packed {
    logic       keep_on;
    logic       rms;
    logic       top;
    logic [1:0] area;
  } lp_mode_t;

  localparam logic [1:0] AREA_HALF = 2'b10;
  localparam logic [1:0] AREA_QTR  = 2'b11;
  localparam int unsigned NSEG  = 4;
  localparam int unsigned SEG_W = 2;
endpackage

// File: rtl/lp_timer.sv
module lp_timer #(
  parameter int unsigned W       = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= RST_VAL;
    else if (load_i)         cnt_q <= val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/lp_mode_reg.sv
module lp_mode_reg
  import lp_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            stage_en_i,
  input  lp_mode_t        stage_val_i,
  input  logic            commit_i,
  output lp_mode_t        mode_o,
  output logic [NSEG-1:0] mask_o
);
  lp_mode_t stage_q, mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
      mode_q  <= '0;
    end else begin
      if (stage_en_i) stage_q <= stage_val_i;
      if (commit_i)   mode_q  <= stage_q;
    end
  end

  assign mode_o = mode_q;

  // quarter region sits at the selected end of the array
  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    logic in_half, in_qtr;
    assign in_half = mode_q.top ? (g >= NSEG/2) : (g < NSEG/2);
    assign in_qtr  = mode_q.top ? (g == NSEG-1) : (g == 0);
    always_comb begin
      case (mode_q.area)
        AREA_HALF: mask_o[g] = in_half;
        AREA_QTR:  mask_o[g] = in_qtr;
        default:   mask_o[g] = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/lp_valid_track.sv
module lp_valid_track
  import lp_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_en_i,
  input  logic [SEG_W-1:0] set_idx_i,
  input  logic             keep_en_i,
  input  logic [NSEG-1:0]  mask_i,
  input  logic             clear_i,
  output logic [NSEG-1:0]  valid_o
);
  for (genvar g = 0; g < NSEG; g++) begin : g_flag
    logic flag_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               flag_q <= 1'b0;
      else if (clear_i)                          flag_q <= 1'b0;
      else if (keep_en_i)                        flag_q <= flag_q & mask_i[g];
      else if (set_en_i && set_idx_i == SEG_W'(g)) flag_q <= 1'b1;
    end
    assign valid_o[g] = flag_q;
  end
endmodule

// File: rtl/lp_fsm.sv
module lp_fsm
  import lp_pkg::*;
#(
  parameter int unsigned TW        = 8,
  parameter logic [TW-1:0] PWRUP_C = '1,
  parameter logic [TW-1:0] WIN_C   = '1,
  parameter logic [TW-1:0] RECOV_C = '1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_ni,
  input  logic          zz_ni,
  input  logic          sel_i,
  input  logic          wr_i,
  input  logic          keep_on_i,
  input  logic          main_done_i,
  input  logic          zz_done_i,
  output lp_state_e     state_o,
  output logic          main_load_o,
  output logic [TW-1:0] main_val_o,
  output logic          zz_load_o,
  output logic          stage_en_o,
  output logic          commit_o,
  output logic          keep_en_o,
  output logic          clear_o
);
  lp_state_e st_q, st_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_PWRUP;
    else         st_q <= st_d;
  end

  always_comb begin
    st_d        = st_q;
    main_load_o = 1'b0;
    main_val_o  = '0;
    zz_load_o   = 1'b0;
    stage_en_o  = 1'b0;
    commit_o    = 1'b0;
    keep_en_o   = 1'b0;
    clear_o     = 1'b0;
    case (st_q)
      ST_PWRUP: begin
        if (!cs_ni) begin
          main_load_o = 1'b1;
          main_val_o  = PWRUP_C;
        end else if (main_done_i) st_d = ST_STBY;
      end
      ST_STBY, ST_ACT: begin
        if (!zz_ni) begin
          st_d        = ST_ZZWAIT;
          main_load_o = 1'b1;
          main_val_o  = WIN_C;
          zz_load_o   = 1'b1;
        end else if (st_q == ST_STBY && !cs_ni && sel_i) st_d = ST_ACT;
        else if (st_q == ST_ACT && (cs_ni || !sel_i))    st_d = ST_STBY;
      end
      ST_ZZWAIT: begin
        if (zz_ni) st_d = ST_STBY;
        else if (wr_i) begin
          st_d       = ST_PROG;
          stage_en_o = 1'b1;
        end else if (main_done_i) begin
          if (keep_on_i) begin
            st_d      = ST_PAR;
            keep_en_o = 1'b1;
          end else begin
            st_d    = ST_DPD;
            clear_o = 1'b1;
          end
        end
      end
      ST_PROG: begin
        if (zz_ni) begin
          commit_o = 1'b1;
          st_d     = ST_STBY;
        end else if (wr_i) stage_en_o = 1'b1;
      end
      ST_PAR: if (zz_ni && zz_done_i) st_d = ST_STBY;
      ST_DPD: begin
        if (zz_ni && zz_done_i) begin
          st_d        = ST_RECOV;
          main_load_o = 1'b1;
          main_val_o  = RECOV_C;
        end
      end
      ST_RECOV: if (main_done_i) st_d = ST_STBY;
      default: st_d = ST_PWRUP;
    endcase
  end

  assign state_o = st_q;
endmodule

// File: rtl/lp_mode_ctrl.sv
module lp_mode_ctrl
  import lp_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_NS = 4,
  parameter int unsigned PWRUP_NS      = 200000,
  parameter int unsigned ENTRY_WIN_NS  = 1000,
  parameter int unsigned ZZ_MIN_NS     = 10000,
  parameter int unsigned RECOV_NS      = 200000,
  parameter int unsigned ADDR_W        = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              we_ni,
  input  logic              lb_ni,
  input  logic              ub_ni,
  input  logic              zz_ni,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [2:0]        state_o,
  output logic [4:0]        mode_o,
  output logic [3:0]        valid_o,
  output logic              ready_o,
  output logic              region_hit_o
);
  localparam int unsigned PWRUP_CYC = (PWRUP_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  localparam int unsigned WIN_CYC   = (ENTRY_WIN_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  localparam int unsigned ZZMIN_CYC = (ZZ_MIN_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  localparam int unsigned RECOV_CYC = (RECOV_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  localparam int unsigned MAX_A     = (PWRUP_CYC > RECOV_CYC) ? PWRUP_CYC : RECOV_CYC;
  localparam int unsigned MAX_B     = (WIN_CYC > ZZMIN_CYC) ? WIN_CYC : ZZMIN_CYC;
  localparam int unsigned MAX_CYC   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned TW        = $clog2(MAX_CYC + 1);

  lp_state_e         st;
  lp_mode_t          mode;
  logic [NSEG-1:0]   mask;
  logic [SEG_W-1:0]  seg;
  logic              sel, wr;
  logic              m_load, m_done, z_load, z_done;
  logic [TW-1:0]     m_val;
  logic              stage_en, commit, keep_en, clear, set_en;

  assign sel = !lb_ni || !ub_ni;
  assign wr  = !cs_ni && !we_ni && sel;
  assign seg = addr_i[ADDR_W-1 -: SEG_W];

  lp_fsm #(
    .TW(TW), .PWRUP_C(TW'(PWRUP_CYC)), .WIN_C(TW'(WIN_CYC)), .RECOV_C(TW'(RECOV_CYC))
  ) u_fsm (
    .clk_i, .rst_ni, .cs_ni, .zz_ni,
    .sel_i(sel), .wr_i(wr), .keep_on_i(mode.keep_on),
    .main_done_i(m_done), .zz_done_i(z_done),
    .state_o(st), .main_load_o(m_load), .main_val_o(m_val), .zz_load_o(z_load),
    .stage_en_o(stage_en), .commit_o(commit), .keep_en_o(keep_en), .clear_o(clear)
  );

  lp_timer #(.W(TW), .RST_VAL(TW'(PWRUP_CYC))) u_main_tmr (
    .clk_i, .rst_ni, .load_i(m_load), .val_i(m_val), .done_o(m_done)
  );

  lp_timer #(.W(TW), .RST_VAL('0)) u_zz_tmr (
    .clk_i, .rst_ni, .load_i(z_load), .val_i(TW'(ZZMIN_CYC)), .done_o(z_done)
  );

  lp_mode_reg u_mode (
    .clk_i, .rst_ni, .stage_en_i(stage_en), .stage_val_i(lp_mode_t'(addr_i[4:0])),
    .commit_i(commit), .mode_o(mode), .mask_o(mask)
  );

  // reduced-size mode drops writes outside the usable region
  assign set_en = (st == ST_ACT) && wr && zz_ni && (!mode.rms || mask[seg]);

  lp_valid_track u_valid (
    .clk_i, .rst_ni, .set_en_i(set_en), .set_idx_i(seg), .keep_en_i(keep_en),
    .mask_i(mask), .clear_i(clear), .valid_o(valid_o)
  );

  assign state_o      = st;
  assign mode_o       = mode;
  assign ready_o      = (st == ST_STBY) || (st == ST_ACT);
  assign region_hit_o = mask[seg];
endmodule

// File: rtl/lp_mode_ctrl_chk.sv
module lp_mode_ctrl_chk
  import lp_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       zz_ni,
  input logic       cs_ni,
  input logic [2:0] state_o,
  input logic [4:0] mode_o,
  input logic [3:0] valid_o,
  input logic       ready_o
);
  logic [3:0] exp_mask;
  always_comb begin
    case (mode_o[1:0])
      2'b10:   exp_mask = mode_o[2] ? 4'b1100 : 4'b0011;
      2'b11:   exp_mask = mode_o[2] ? 4'b1000 : 4'b0001;
      default: exp_mask = 4'b1111;
    endcase
  end

  a_r3_mode_commit_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(state_o == ST_PROG && zz_ni) |=> $stable(mode_o));

  a_r5_dpd_from_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o != ST_ZZWAIT && state_o != ST_DPD) |=> state_o != ST_DPD);

  a_r5_par_from_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o != ST_ZZWAIT && state_o != ST_PAR) |=> state_o != ST_PAR);

  a_r5_par_bit4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == ST_PAR |-> mode_o[4]);

  a_r5_dpd_bit4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == ST_DPD |-> !mode_o[4]);

  a_r8_dpd_no_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == ST_DPD |-> valid_o == 4'b0000);

  a_r7_par_in_region: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == ST_PAR |-> (valid_o & ~exp_mask) == 4'b0000);

  a_r8_recov_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == ST_RECOV |=> (state_o == ST_RECOV || state_o == ST_STBY));

  a_r7_ready_states: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (state_o == ST_STBY || state_o == ST_ACT));

  a_r2_active_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_ACT && cs_ni) |=> state_o != ST_ACT);
endmodule

bind lp_mode_ctrl lp_mode_ctrl_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .zz_ni(zz_ni), .cs_ni(cs_ni),
  .state_o(state_o), .mode_o(mode_o), .valid_o(valid_o), .ready_o(ready_o)
);

// File: tb/tb_lp_mode_ctrl.sv
`timescale 1ns/1ps
module tb_lp_mode_ctrl;
  localparam int P_NS = 4;
  localparam int WIN = 20, ZMIN = 30, RECOV = 50, PWRUP = 100;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, we_n = 1'b1, lb_n = 1'b1, ub_n = 1'b1, zz_n = 1'b1;
  logic [17:0] addr = '0;
  logic [2:0] state;
  logic [4:0] mode;
  logic [3:0] valid;
  logic ready, hit;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  lp_mode_ctrl #(
    .CLK_PERIOD_NS(P_NS), .PWRUP_NS(PWRUP*P_NS), .ENTRY_WIN_NS(WIN*P_NS),
    .ZZ_MIN_NS(ZMIN*P_NS), .RECOV_NS(RECOV*P_NS), .ADDR_W(18)
  ) dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .we_ni(we_n), .lb_ni(lb_n), .ub_ni(ub_n),
    .zz_ni(zz_n), .addr_i(addr), .state_o(state), .mode_o(mode), .valid_o(valid),
    .ready_o(ready), .region_hit_o(hit)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [3:0] region(input logic [4:0] m);
    case (m[1:0])
      2'b10:   return m[2] ? 4'b1100 : 4'b0011;
      2'b11:   return m[2] ? 4'b1000 : 4'b0001;
      default: return 4'b1111;
    endcase
  endfunction

  task automatic prog_mode(input logic [4:0] m, input logic [4:0] prev);
    zz_n = 1'b0; tick(2);
    check("R3 pending state", state, 3);
    addr = {13'h0A5A, m};
    cs_n = 1'b0; we_n = 1'b0; lb_n = 1'b0; ub_n = 1'b0;
    tick(3);
    check("R3 programming state", state, 4);
    cs_n = 1'b1; we_n = 1'b1; lb_n = 1'b1; ub_n = 1'b1;
    tick(1);
    check("R3 mode held until rise", mode, prev);
    zz_n = 1'b1; tick(2);
    check("R3 mode committed", mode, m);
    check("R3 back to standby", state, 1);
  endtask

  task automatic wr_quarter(input int q);
    addr = {q[1:0], 16'h0040};
    cs_n = 1'b0; we_n = 1'b0; lb_n = 1'b0;
    tick(3);
    cs_n = 1'b1; we_n = 1'b1; lb_n = 1'b1;
    tick(2);
  endtask

  task automatic sleep_and_wake(input logic keep);
    zz_n = 1'b0; tick(WIN + 12);
    check("R5 sleep state", state, keep ? 5 : 6);
    check("R7 ready low in sleep", ready, 0);
    zz_n = 1'b1; tick(3);
    if (keep) check("R9 wake to standby", state, 1);
    else begin
      check("R8 recovery state", state, 7);
      check("R8 ready low in recovery", ready, 0);
      tick(RECOV + 5);
      check("R8 standby after recovery", state, 1);
      check("R8 ready after recovery", ready, 1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [4:0] prev;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    check("R1 reset state", state, 0);
    check("R1 reset ready", ready, 0);
    check("R1 reset valid", valid, 0);
    check("R1 reset mode", mode, 0);
    tick(60);
    cs_n = 1'b0; tick(2); cs_n = 1'b1;
    tick(78);
    check("R1 power-up restarted", ready, 0);
    tick(40);
    check("R1 standby after power-up", state, 1);
    check("R1 ready after power-up", ready, 1);

    // R2 active entry/exit
    cs_n = 1'b0; lb_n = 1'b0; tick(2);
    check("R2 active on lower byte", state, 2);
    lb_n = 1'b1; tick(2);
    check("R2 standby on both bytes off", state, 1);
    ub_n = 1'b0; tick(2);
    check("R2 active on upper byte", state, 2);
    cs_n = 1'b1; ub_n = 1'b1; tick(2);
    check("R2 standby on cs high", state, 1);

    // R4/R5/R7/R8 sweep over all mode values
    prev = 5'd0;
    for (int m = 0; m < 32; m++) begin
      prog_mode(5'(m), prev);
      prev = 5'(m);
      for (int q = 0; q < 4; q++) begin
        addr = {q[1:0], 16'h1234}; #1;
        check("R4 region hit", hit, int'(region(5'(m))[q]));
      end
      for (int q = 0; q < 4; q++) wr_quarter(q);
      sleep_and_wake(m[4]);
      check("R7 R8 valid after sleep", valid, m[4] ? int'(region(5'(m))) : 0);
    end

    // R6 aborted sleep (mode 31 in force)
    zz_n = 1'b0; tick(5); zz_n = 1'b1; tick(3);
    check("R6 abort to standby", state, 1);
    check("R6 mode unchanged", mode, 31);
    tick(WIN + 10);
    check("R6 no sleep after abort", state, 1);

    // R9 deferred exit
    zz_n = 1'b0; tick(24);
    check("R9 in partial refresh", state, 5);
    zz_n = 1'b1; tick(3);
    check("R9 exit held off", state, 5);
    tick(10);
    check("R9 exit after minimum", state, 1);

    // R10/R11 reduced-size masking and persistence
    prog_mode(5'd0, 5'd31);
    sleep_and_wake(1'b0);
    check("R8 valid cleared", valid, 0);
    prog_mode(5'b11110, 5'd0);
    wr_quarter(0);
    wr_quarter(3);
    check("R10 write outside region dropped", valid, 4'b1000);
    wr_quarter(2);
    check("R10 write inside region marks", valid, 4'b1100);
    sleep_and_wake(1'b1);
    check("R11 mode persists", mode, 5'b11110);
    addr = 18'h10000; #1;
    check("R11 region after wake q1", hit, 0);
    addr = 18'h20000; #1;
    check("R11 region after wake q2", hit, 1);
    check("R7 valid kept in region", valid, 4'b1100);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule